// File: doc/BRIEF.md
# I2C Master Byte Controller with Access-Triggered Transfers

This block is the bus-side engine of an I2C master. Software sees two registers. The control register holds the master enable, the transfer direction and an acknowledge-suppress bit. The data register is 8 bits wide. Transfers have no separate start command. They begin as a side effect of a data-register access. A write starts a transmit only while the direction bit selects transmit. A read starts a receive only while the direction bit selects receive.

Setting master enable from idle puts a START on the bus. The engine then holds SCL low and waits for byte commands. Each byte occupies nine SCL periods: eight data bits, most significant first, followed by an acknowledge slot. The first byte after a START is the address byte, which software composes itself. Clearing master enable while the engine waits puts a STOP on the bus, and both lines are then released. Both lines are open-drain: an output high means the block pulls that line low.

SCL comes from a fixed divider of the system clock. One SCL period is four quarter-phases of `QTR_CYC` system clocks each. SDA only moves during the low half of SCL, except for START and STOP.

Top module: `i2c_byte_ctrl`

## Requirements
- R1: After reset the data register reads 0x00, the control register reads 0x00, `scl_oe`, `sda_oe` and `busy` are low, and the bus lines are released.
- R2: The control register is selected when `reg_sel`=0. Its fields are: bit 0 master enable, bit 1 direction (1 = transmit, 0 = receive), bit 2 suppress acknowledge after a received byte. It reads back those three bits with zeros above them.
- R3: Setting master enable while idle produces a START, meaning SDA falls while SCL is high. SCL is then held low while the engine waits for a command.
- R4: A data-register write (`reg_sel`=1) with direction = transmit, while waiting, sends the written byte most-significant bit first. The first byte after a START carries the 7-bit target address in bits 7..1 and the read/write flag in bit 0, and it is sent unchanged.
- R5: A data-register read with direction = receive, while waiting, starts reception of the next byte. A data read always returns the last byte received and never the last byte written.
- R6: A data-register read while direction = transmit starts no bus activity. The direction value in force at the cycle of the read decides this.
- R7: After a transmitted byte, the level sampled on SDA during the ninth SCL high phase is stored on `nack` (1 = not acknowledged).
- R8: During the ninth clock after a received byte, the block pulls SDA low, unless the suppress bit was set when that reception started. In that case it leaves SDA released.
- R9: `busy` is high for exactly 36·`QTR_CYC` cycles, starting the cycle after an accepted access. Data-register accesses made while `busy` is high, including its last cycle, are ignored.
- R10: Within a byte, SDA changes only while SCL is low. The SCL period is 4·`QTR_CYC` system clocks. Edges of SDA while SCL is high appear only as START or STOP.
- R11: Clearing master enable while waiting produces a STOP: SDA rises while SCL is high. Both lines are then released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data reads have side effects) |
| reg_sel | input | 1 | 0 selects control register, 1 selects data register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_i | input | 1 | Sampled SDA line level |
| busy | output | 1 | A byte is in flight |
| nack | output | 1 | Acknowledge level seen after the last transmitted byte |

## Verification
The sharpest collision is a data-register access that lands in the very cycle the ninth clock finishes. Completion of the current byte and the start of a new one compete for that same edge. The bench waits for its own busy-window counter to reach its final cycle and issues a data write exactly there. It then expects `busy` to stay low, no further SCL edges, and no extra byte at the slave model. A second overlap is a data read made right after the direction bit has been switched to transmit. The bench judges that case by the returned byte and by the absence of new SCL edges.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int BYTE_W    = 8;
    localparam int SLOT_N    = BYTE_W + 1;            // data bits plus acknowledge slot
    localparam int SLOT_W    = $clog2(SLOT_N + 1);
    localparam int CTL_W     = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HOLD,
        ST_XFER,
        ST_STOP
    } eng_state_e;

    typedef struct packed {
        logic ack_off;
        logic tx_dir;
        logic master_en;
    } ctl_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pins_t;

    // Line pattern per state and quarter phase; the data-slot SDA is added by the engine.
    function automatic pins_t frame_pins(eng_state_e st, logic [1:0] q);
        pins_t p;
        p = '0;
        case (st)
            ST_START: begin
                p.scl_low = (q == 2'd3);
                p.sda_low = (q >= 2'd2);
            end
            ST_HOLD:  p.scl_low = 1'b1;
            ST_XFER:  p.scl_low = (q == 2'd0) || (q == 2'd3);
            ST_STOP: begin
                p.scl_low = (q == 2'd0);
                p.sda_low = (q <= 2'd1);
            end
            default:  p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
    parameter int QTR_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(QTR_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cb_regs.sv
module i2cb_regs
    import i2cb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             in_hold,
    input  logic             rx_done,
    input  byte_t            rx_byte,
    output ctl_t             ctl,
    output byte_t            rdata,
    output logic             go_tx,
    output logic             go_rx
);
    byte_t rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            rx_q <= '0;
        end else begin
            if (reg_wr && !reg_sel) ctl  <= ctl_t'(ctl_wdata);
            if (rx_done)            rx_q <= rx_byte;
        end
    end

    // Side effects of data-register accesses, gated by direction and engine state
    assign go_tx = reg_wr && reg_sel &&  ctl.tx_dir && in_hold;
    assign go_rx = reg_rd && reg_sel && !ctl.tx_dir && in_hold;

    always_comb begin
        if (reg_sel) rdata = rx_q;
        else         rdata = {{(BYTE_W - CTL_W){1'b0}}, ctl};
    end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
    import i2cb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  master_en,
    input  logic  ack_off_in,
    input  logic  go_tx,
    input  logic  go_rx,
    input  byte_t tx_byte,
    input  logic  sda_i,
    output logic  scl_oe,
    output logic  sda_oe,
    output logic  busy,
    output logic  in_hold,
    output logic  run,
    output logic  rx_done,
    output byte_t rx_byte,
    output logic  nack
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_N - 1);

    eng_state_e        state;
    logic [1:0]        q;
    logic [SLOT_W-1:0] slot;
    byte_t             sh;
    logic              samp;
    logic              rx_mode;
    logic              ack_off;
    logic              nack_q;
    logic              slot_end;
    pins_t             fp;

    assign slot_end = (state == ST_XFER) && tick && (q == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            q       <= '0;
            slot    <= '0;
            sh      <= '0;
            samp    <= 1'b0;
            rx_mode <= 1'b0;
            ack_off <= 1'b0;
            nack_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (master_en) begin
                    state <= ST_START;
                    q     <= '0;
                end
                ST_START: if (tick) begin
                    q <= q + 2'd1;
                    if (q == 2'd3) state <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (go_tx) begin
                        state   <= ST_XFER;
                        q       <= '0;
                        slot    <= '0;
                        sh      <= tx_byte;
                        rx_mode <= 1'b0;
                    end else if (go_rx) begin
                        state   <= ST_XFER;
                        q       <= '0;
                        slot    <= '0;
                        sh      <= '0;
                        rx_mode <= 1'b1;
                        ack_off <= ack_off_in;
                    end else if (!master_en) begin
                        state <= ST_STOP;
                        q     <= '0;
                    end
                end
                ST_XFER: if (tick) begin
                    q <= q + 2'd1;
                    if (q == 2'd2) samp <= sda_i;
                    if (q == 2'd3) begin
                        if (slot == LAST_SLOT) begin
                            state <= ST_HOLD;
                            if (!rx_mode) nack_q <= samp;
                        end else begin
                            sh   <= {sh[BYTE_W-2:0], samp};
                            slot <= slot + 1'b1;
                        end
                    end
                end
                ST_STOP: if (tick) begin
                    q <= q + 2'd1;
                    if (q == 2'd3) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        fp     = frame_pins(state, q);
        scl_oe = fp.scl_low;
        sda_oe = fp.sda_low;
        if (state == ST_XFER) begin
            if (slot < SLOT_W'(BYTE_W)) sda_oe = !rx_mode && !sh[BYTE_W-1];
            else                        sda_oe = rx_mode && !ack_off;
        end
    end

    assign busy    = (state == ST_XFER);
    assign in_hold = (state == ST_HOLD);
    assign run     = (state == ST_START) || (state == ST_XFER) || (state == ST_STOP);
    assign rx_done = slot_end && (slot == LAST_SLOT) && rx_mode;
    assign rx_byte = sh;
    assign nack    = nack_q;
endmodule

// File: rtl/i2c_byte_ctrl.sv
module i2c_byte_ctrl
    import i2cb_pkg::*;
#(
    parameter int QTR_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_i,
    output logic        busy,
    output logic        nack
);
    ctl_t  ctl;
    logic  in_hold;
    logic  go_tx;
    logic  go_rx;
    logic  tick;
    logic  run;
    logic  rx_done;
    byte_t rx_byte;

    i2cb_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .ctl_wdata (reg_wdata[CTL_W-1:0]),
        .in_hold   (in_hold),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .ctl       (ctl),
        .rdata     (reg_rdata),
        .go_tx     (go_tx),
        .go_rx     (go_rx)
    );

    i2cb_qtick #(.QTR_CYC(QTR_CYC)) u_qtick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    i2cb_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .master_en  (ctl.master_en),
        .ack_off_in (ctl.ack_off),
        .go_tx      (go_tx),
        .go_rx      (go_rx),
        .tx_byte    (reg_wdata),
        .sda_i      (sda_i),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .busy       (busy),
        .in_hold    (in_hold),
        .run        (run),
        .rx_done    (rx_done),
        .rx_byte    (rx_byte),
        .nack       (nack)
    );
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk (
    input logic clk,
    input logic rst,
    input logic reg_wr,
    input logic reg_rd,
    input logic reg_sel,
    input logic ctl_tx,
    input logic in_hold,
    input logic busy,
    input logic scl_oe,
    input logic sda_oe
);
    p_tx_start_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && ctl_tx && in_hold) |=> busy);

    p_rx_start_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel && !ctl_tx && in_hold) |=> busy);

    p_rd_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel && ctl_tx && !busy) |=> !busy);

    p_end_to_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (in_hold && scl_oe));

    p_sda_steady_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

    p_hold_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
        in_hold |-> scl_oe);
endmodule

bind i2c_byte_ctrl i2cb_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd),
    .reg_sel (reg_sel),
    .ctl_tx  (ctl.tx_dir),
    .in_hold (in_hold),
    .busy    (busy),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe)
);

// File: tb/i2c_byte_ctrl_tb.sv
module i2c_byte_ctrl_tb;
    localparam int QTR      = 4;
    localparam int BYTE_CYC = 36 * QTR;
    localparam logic [6:0] SLV = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe, busy, nack;
    logic       slv_oe = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slv_oe);

    i2c_byte_ctrl #(.QTR_CYC(QTR)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_i(sda_line), .busy(busy), .nack(nack)
    );

    int  checks = 0, errs = 0;
    bit  done = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model of the busy window, compared every clock
    logic exp_go = 1'b0;
    int   rem = 0, busy_err = 0;
    always @(posedge clk) begin
        if (rst)         rem = 0;
        else if (exp_go) rem = BYTE_CYC;
        else if (rem > 0) rem--;
    end
    always @(negedge clk) if (!rst && (busy !== (rem > 0))) busy_err++;

    // Behavioural slave on the wired bus
    int   starts = 0, stops = 0, rises = 0, bitc = 0, last_rise = 0, gap = 0, cyc = 0;
    logic scl_p = 1'b1, sda_p = 1'b1, in_frame = 1'b0, is_addr = 1'b0, rd_mode = 1'b0, addressed = 1'b0;
    logic [7:0] shv = 8'h00, cur = 8'h00, last_addr = 8'h00;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    logic       mackq[$];

    always @(posedge clk) begin
        cyc++;
        if (scl_p && scl_line && sda_p && !sda_line) begin
            starts++; in_frame = 1; bitc = 0; is_addr = 1; slv_oe <= 1'b0;
        end else if (scl_p && scl_line && !sda_p && sda_line) begin
            stops++; in_frame = 0; slv_oe <= 1'b0;
        end else if (!scl_p && scl_line) begin
            rises++;
            if (in_frame && bitc >= 1) gap = cyc - last_rise;
            last_rise = cyc;
            if (in_frame) begin
                if (bitc < 8) shv = {shv[6:0], sda_line};
                else if (rd_mode && !is_addr) mackq.push_back(sda_line);
                bitc++;
            end
        end else if (scl_p && !scl_line && in_frame) begin
            if (bitc == 8) begin
                if (is_addr) begin
                    last_addr = shv; addressed = (shv[7:1] == SLV); rd_mode = shv[0];
                    slv_oe <= (shv[7:1] == SLV);
                end else if (!rd_mode) begin
                    rxq.push_back(shv); slv_oe <= addressed;
                end else slv_oe <= 1'b0;
            end else if (bitc == 9) begin
                bitc = 0;
                if (is_addr) begin
                    is_addr = 0;
                    if (rd_mode && addressed && txq.size() > 0) begin
                        cur = txq.pop_front(); slv_oe <= !cur[7];
                    end else slv_oe <= 1'b0;
                end else if (rd_mode && addressed && mackq.size() > 0 && mackq[$] == 1'b0 && txq.size() > 0) begin
                    cur = txq.pop_front(); slv_oe <= !cur[7];
                end else slv_oe <= 1'b0;
            end else if (bitc >= 1 && bitc <= 7 && rd_mode && addressed && !is_addr) begin
                slv_oe <= !cur[7 - bitc];
            end
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d, input bit go);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d; exp_go = go;
        @(negedge clk);
        reg_wr = 0; exp_go = 0;
    endtask

    task automatic rd_reg(input logic sel, input bit go, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1; reg_sel = sel; exp_go = go;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 0; exp_go = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int r;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd_reg(1, 0, v); chk(v == 8'h00, "R1", "data reg after reset", v, 0);
        rd_reg(0, 0, v); chk(v == 8'h00, "R1", "ctl reg after reset", v, 0);
        chk(scl_line && sda_line && !busy, "R1", "lines released, idle", {scl_line, sda_line, busy}, 3'b110);

        // R3 START, R2 control readback
        wr_reg(0, 8'h03, 0); idle(30);
        chk(starts == 1, "R3", "START count", starts, 1);
        chk(scl_line == 0, "R3", "SCL held low", scl_line, 0);
        rd_reg(0, 0, v); chk(v == 8'h03, "R2", "ctl readback", v, 8'h03);

        // R4 address byte, R7 acknowledged
        wr_reg(1, {SLV, 1'b0}, 1); idle(BYTE_CYC + 10);
        chk(last_addr == {SLV, 1'b0}, "R4", "address byte on wire", last_addr, {SLV, 1'b0});
        chk(nack == 0, "R7", "ack after address", nack, 0);
        wr_reg(1, 8'hC3, 1); idle(BYTE_CYC + 10);
        chk(rxq.size() == 1 && rxq[0] == 8'hC3, "R4", "data byte MSB first", rxq.size() > 0 ? rxq[0] : -1, 8'hC3);

        // R6 read in transmit mode does nothing; R5 read returns received data, not written
        r = rises;
        rd_reg(1, 0, v); idle(100);
        chk(v == 8'h00, "R5", "read does not echo written byte", v, 0);
        chk(rises == r, "R6", "no SCL edge after read in transmit", rises - r, 0);

        // R9 access while busy ignored
        wr_reg(1, 8'h11, 1); idle(20);
        wr_reg(1, 8'h22, 0); idle(BYTE_CYC + 10);
        chk(rxq.size() == 2 && rxq[1] == 8'h11, "R9", "write while busy ignored", rxq.size(), 2);

        // R9 write in final busy cycle ignored
        wr_reg(1, 8'h33, 1);
        while (rem != 1) @(negedge clk);
        reg_wr = 1; reg_sel = 1; reg_wdata = 8'h44;
        @(negedge clk);
        reg_wr = 0;
        r = rises; idle(100);
        chk(rises == r && rxq.size() == 3, "R9", "write at last busy cycle ignored", rxq.size(), 3);
        chk(rxq[2] == 8'h33, "R9", "last byte sent", rxq[2], 8'h33);

        // R11 STOP
        wr_reg(0, 8'h00, 0); idle(30);
        chk(stops == 1, "R11", "STOP count", stops, 1);
        chk(scl_line && sda_line, "R11", "lines released after STOP", {scl_line, sda_line}, 2'b11);

        // R7 not acknowledged
        wr_reg(0, 8'h03, 0); idle(30);
        wr_reg(1, 8'h22, 1); idle(BYTE_CYC + 10);
        chk(nack == 1, "R7", "nack for absent target", nack, 1);
        wr_reg(0, 8'h00, 0); idle(30);

        // Receive sequence
        txq.push_back(8'hA7); txq.push_back(8'h3C);
        wr_reg(0, 8'h03, 0); idle(30);
        wr_reg(1, {SLV, 1'b1}, 1); idle(BYTE_CYC + 10);
        chk(nack == 0, "R7", "ack after read address", nack, 0);
        wr_reg(0, 8'h01, 0);
        rd_reg(1, 1, v); idle(BYTE_CYC + 10);
        chk(v == 8'h00, "R5", "first read returns prior data", v, 0);
        wr_reg(0, 8'h05, 0);
        rd_reg(1, 1, v);
        chk(v == 8'hA7, "R5", "received byte", v, 8'hA7);
        chk(mackq.size() == 1 && mackq[0] == 1'b0, "R8", "master ack on first byte", mackq.size(), 1);
        idle(BYTE_CYC + 10);
        wr_reg(0, 8'h03, 0);
        r = rises;
        rd_reg(1, 0, v); idle(100);
        chk(v == 8'h3C, "R5", "second received byte", v, 8'h3C);
        chk(rises == r, "R6", "direction switched before read", rises - r, 0);
        chk(mackq.size() == 2 && mackq[1] == 1'b1, "R8", "suppressed ack on last byte", mackq.size() > 1 ? mackq[1] : -1, 1);
        wr_reg(0, 8'h00, 0); idle(30);

        chk(starts == 3 && stops == 3, "R10", "SDA edges while SCL high only START/STOP", starts * 16 + stops, 8'h33);
        chk(gap == 4 * QTR, "R10", "SCL period", gap, 4 * QTR);
        chk(busy_err == 0, "R9", "busy window trace", busy_err, 0);
        finish_run();
    end
endmodule